// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit walks a byte-wide instruction memory one byte per clock, starting at its program counter. It assembles a single instruction of one to six bytes and splits it into its fields. The operation nibble of the opening byte fixes the total length. It also fixes whether a register-specifier byte follows, and whether a 32-bit constant follows, stored least significant byte first. The finished instruction is offered to the execute stage over a valid/ready handshake. It comes with the address of the instruction that follows it and a flag for illegal encodings.

The memory read is combinational: the byte at `mem_addr` is expected on `mem_byte` in the same cycle. The downstream stage redirects fetching after a jump, call or return by pulsing `pc_load` with the new address. Fetching stops for good after a halt or an illegal instruction has been handed over, and only reset clears that condition.

Top module: `ifetch_unit`

## Requirements
- R1: After reset `out_valid`, `halted` and `bad_instr` are 0 and `mem_addr` equals the reset address (0 by default).
- R2: The length comes from the operation code in bits 7:4 of the opening byte: codes 0, 1 and 9 take 1 byte; codes 2, 6, 0xA and 0xB take 2; codes 7 and 8 take 5; codes 3, 4 and 5 take 6. One byte is read per cycle, so `out_valid` rises L cycles after fetching of an L-byte instruction begins.
- R3: `icode` carries bits 7:4 and `ifun` carries bits 3:0 of the opening byte.
- R4: For codes 2, 3, 4, 5, 6, 0xA and 0xB, the second byte supplies `ra` (bits 7:4) and `rb` (bits 3:0). For all other codes both read 8, the no-register ID.
- R5: `valc` is built least significant byte first. For codes 3, 4 and 5 it comes from bytes 3 to 6, and for codes 7 and 8 from bytes 2 to 5. For every other code it is 0.
- R6: `next_pc` equals the instruction's start address plus its length.
- R7: While `out_valid` is high and `out_ready` is low, all output fields hold steady. One cycle after acceptance, `mem_addr` equals the accepted `next_pc`.
- R8: An operation code above 0xB is illegal. So is a function code outside the allowed set: 0 to 3 for code 6, 0 to 6 for code 7, and only 0 for the other codes. An illegal opening byte is presented at once with `bad_instr` high. After it is accepted, `halted` rises and no further instruction is offered.
- R9: Once a halt (code 1) is accepted, `halted` stays high, `out_valid` stays low, and `pc_load` is ignored until reset.
- R10: While not halted, a `pc_load` pulse discards any partial or waiting instruction. In the next cycle `out_valid` is low and `mem_addr` equals `pc_new`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_load | input | 1 | Redirect fetching to `pc_new` |
| pc_new | input | 32 | Redirect target address |
| mem_addr | output | 32 | Byte address being read |
| mem_byte | input | 8 | Byte at `mem_addr`, same cycle |
| out_valid | output | 1 | Decoded instruction available |
| out_ready | input | 1 | Execute stage accepts the instruction |
| icode | output | 4 | Operation code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register ID |
| rb | output | 4 | Second register ID |
| valc | output | 32 | Constant field |
| next_pc | output | 32 | Address of the following instruction |
| bad_instr | output | 1 | Illegal encoding flag |
| halted | output | 1 | Fetching stopped until reset |

## Verification
A wrong byte counter surfaces within one instruction. `out_valid` rises a cycle early or late, a constant byte lands in the wrong lane of `valc`, or `mem_addr` after acceptance misses the start of the next instruction. A wrong legality or halt state shows on the very acceptance that follows it: `halted` does or does not rise, and the next fields are offered or never arrive. A faulty redirect path shows on `mem_addr` one cycle after `pc_load`.

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_load,
  input  logic [31:0] pc_new,
  output logic [31:0] mem_addr,
  input  logic [7:0]  mem_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  icode,
  output logic [3:0]  ifun,
  output logic [3:0]  ra,
  output logic [3:0]  rb,
  output logic [31:0] valc,
  output logic [31:0] next_pc,
  output logic        bad_instr,
  output logic        halted
);
  localparam logic [1:0] S_FETCH = 2'd0, S_HOLD = 2'd1, S_STOP = 2'd2;
  localparam logic [3:0] NO_REG = 4'h8;

  function automatic logic [2:0] len_of(input logic [3:0] c);
    case (c)
      4'h2, 4'h6, 4'hA, 4'hB: len_of = 3'd2;
      4'h3, 4'h4, 4'h5:       len_of = 3'd6;
      4'h7, 4'h8:             len_of = 3'd5;
      default:                len_of = 3'd1;
    endcase
  endfunction

  function automatic logic has_reg(input logic [3:0] c);
    has_reg = (c >= 4'h2 && c <= 4'h6) || c == 4'hA || c == 4'hB;
  endfunction

  function automatic logic fn_ok(input logic [3:0] c, input logic [3:0] f);
    if (c == 4'h6)       fn_ok = f <= 4'd3;
    else if (c == 4'h7)  fn_ok = f <= 4'd6;
    else if (c <= 4'hB)  fn_ok = f == 4'd0;
    else                 fn_ok = 1'b0;
  endfunction

  logic [1:0]  state_q;
  logic [31:0] pc_q;
  logic [2:0]  cnt_q;
  logic [3:0]  icode_q, ifun_q, ra_q, rb_q;
  logic [31:0] valc_q;
  logic        bad_q;
  logic [2:0]  cur_len;
  logic [1:0]  kidx;

  assign cur_len   = len_of(icode_q);
  assign kidx      = 2'(cnt_q - 3'd1 - {2'b0, has_reg(icode_q)});
  assign mem_addr  = pc_q + {29'b0, cnt_q};
  assign next_pc   = pc_q + {29'b0, cur_len};
  assign out_valid = state_q == S_HOLD;
  assign halted    = state_q == S_STOP;
  assign icode     = icode_q;
  assign ifun      = ifun_q;
  assign ra        = ra_q;
  assign rb        = rb_q;
  assign valc      = valc_q;
  assign bad_instr = bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      pc_q    <= RESET_PC;
      cnt_q   <= 3'd0;
      icode_q <= 4'h0;
      ifun_q  <= 4'h0;
      ra_q    <= NO_REG;
      rb_q    <= NO_REG;
      valc_q  <= 32'h0;
      bad_q   <= 1'b0;
    end else if (pc_load && state_q != S_STOP) begin
      state_q <= S_FETCH;
      pc_q    <= pc_new;
      cnt_q   <= 3'd0;
      bad_q   <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: begin
          if (cnt_q == 3'd0) begin
            icode_q <= mem_byte[7:4];
            ifun_q  <= mem_byte[3:0];
            ra_q    <= NO_REG;
            rb_q    <= NO_REG;
            valc_q  <= 32'h0;
            if (!fn_ok(mem_byte[7:4], mem_byte[3:0])) begin
              bad_q   <= 1'b1;
              state_q <= S_HOLD;
            end else if (len_of(mem_byte[7:4]) == 3'd1) begin
              state_q <= S_HOLD;
            end else begin
              cnt_q <= 3'd1;
            end
          end else begin
            if (has_reg(icode_q) && cnt_q == 3'd1) begin
              ra_q <= mem_byte[7:4];
              rb_q <= mem_byte[3:0];
            end else begin
              valc_q[{kidx, 3'b000} +: 8] <= mem_byte;
            end
            if (cnt_q == cur_len - 3'd1) begin
              cnt_q   <= 3'd0;
              state_q <= S_HOLD;
            end else begin
              cnt_q <= cnt_q + 3'd1;
            end
          end
        end
        S_HOLD: begin
          if (out_ready) begin
            if (bad_q || icode_q == 4'h1) begin
              state_q <= S_STOP;
            end else begin
              pc_q    <= next_pc;
              cnt_q   <= 3'd0;
              state_q <= S_FETCH;
            end
          end
        end
        default: state_q <= S_STOP;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_load,
  input logic [31:0] pc_new,
  input logic [31:0] mem_addr,
  input logic [7:0]  mem_byte,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  icode,
  input logic [3:0]  ifun,
  input logic [3:0]  ra,
  input logic [3:0]  rb,
  input logic [31:0] valc,
  input logic [31:0] next_pc,
  input logic        bad_instr,
  input logic        halted
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !pc_load |=> out_valid && $stable(icode) && $stable(ifun)
      && $stable(ra) && $stable(rb) && $stable(valc) && $stable(next_pc));

  // R7
  resume_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !pc_load && !bad_instr && icode != 4'h1
      |=> !out_valid && mem_addr == $past(next_pc));

  // R8
  bad_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && bad_instr && !pc_load |=> halted);

  // R9
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && icode == 4'h1 && !pc_load |=> halted);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !out_valid);

  // R10
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load && !halted |=> !out_valid && mem_addr == $past(pc_new));

  // R4
  no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !bad_instr && (icode <= 4'h1 || icode == 4'h7 || icode == 4'h8 || icode == 4'h9)
      |-> ra == 4'h8 && rb == 4'h8);
endmodule

bind ifetch_unit ifetch_unit_chk i_chk (.*);

// File: tb/test_ifetch_unit.sv
`timescale 1ns/1ps
module test_ifetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_load = 1'b0;
  logic [31:0] pc_new = 32'h0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_byte;
  logic        out_valid, out_ready = 1'b0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, next_pc;
  logic        bad_instr, halted;

  logic [7:0] mem [256];
  int checks = 0, fails = 0;

  localparam int NI = 31;
  logic [3:0]  e_ic [NI];
  logic [3:0]  e_fn [NI];
  logic [3:0]  e_ra [NI];
  logic [3:0]  e_rb [NI];
  logic [31:0] e_vc [NI];
  logic [31:0] e_np [NI];

  always #5 clk = ~clk;
  assign mem_byte = mem[mem_addr[7:0]];

  ifetch_unit i_ifetch_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [3:0] c);
    case (c)
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      4'h3, 4'h4, 4'h5: return 6;
      4'h7, 4'h8: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic bit has_reg(input logic [3:0] c);
    return (c >= 4'h2 && c <= 4'h6) || c == 4'hA || c == 4'hB;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; out_ready = 1'b0; pc_load = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic gen_prog();
    logic [3:0] codes [11] = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB};
    int a = 0;
    for (int i = 0; i < NI; i++) begin
      logic [3:0] c, f, r1, r2;
      logic [31:0] v;
      int L;
      c = (i == NI - 1) ? 4'h1 : codes[$urandom % 11];
      f = (c == 4'h6) ? 4'($urandom % 4) : (c == 4'h7) ? 4'($urandom % 7) : 4'h0;
      r1 = 4'($urandom % 9); r2 = 4'($urandom % 9);
      if (c == 4'h3) r1 = 4'h8;
      if (c == 4'hA || c == 4'hB) r2 = 4'h8;
      v = $urandom;
      L = len_of(c);
      mem[a] = {c, f};
      if (has_reg(c)) mem[a + 1] = {r1, r2};
      if (L >= 5) for (int k = 0; k < 4; k++) mem[a + L - 4 + k] = v[8*k +: 8];
      e_ic[i] = c; e_fn[i] = f;
      e_ra[i] = has_reg(c) ? r1 : 4'h8;
      e_rb[i] = has_reg(c) ? r2 : 4'h8;
      e_vc[i] = (L >= 5) ? v : 32'h0;
      a += L;
      e_np[i] = 32'(a);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));

    // R1 reset state
    clear_mem();
    mem[0] = 8'h30; mem[1] = 8'h82; mem[2] = 8'hcd; mem[3] = 8'hab;
    do_reset();
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 bad", 32'(bad_instr), 0);
    chk("R1 addr", mem_addr, 0);

    // R2 six-byte timing, R3/R4/R5/R6 fields
    wait_valid(n);
    chk("R2 six-byte cycles", 32'(n), 6);
    chk("R3 icode", 32'(icode), 3);
    chk("R3 ifun", 32'(ifun), 0);
    chk("R4 ra", 32'(ra), 8);
    chk("R4 rb", 32'(rb), 2);
    chk("R5 valc", valc, 32'h0000abcd);
    chk("R6 next_pc", next_pc, 6);

    // R8 illegal operation code
    clear_mem(); mem[0] = 8'hC0;
    do_reset();
    wait_valid(n);
    chk("R8 bad opcode cycles", 32'(n), 1);
    chk("R8 bad flag", 32'(bad_instr), 1);
    out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
    chk("R8 halted", 32'(halted), 1);
    repeat (3) @(negedge clk);
    chk("R8 no more output", 32'(out_valid), 0);

    // R8 illegal function codes
    clear_mem(); mem[0] = 8'h77;
    do_reset(); wait_valid(n);
    chk("R8 bad jump function", 32'(bad_instr), 1);
    clear_mem(); mem[0] = 8'h64; mem[1] = 8'h01;
    do_reset(); wait_valid(n);
    chk("R8 bad alu function", 32'(bad_instr), 1);
    clear_mem(); mem[0] = 8'h76;
    do_reset(); wait_valid(n);
    chk("R8 legal jump function", 32'(bad_instr), 0);
    chk("R2 five-byte cycles", 32'(n), 5);

    // R10 redirect mid-instruction
    clear_mem();
    mem[0] = 8'h30; mem[1] = 8'h81;
    mem[8'h40] = 8'h20; mem[8'h41] = 8'h43;
    do_reset();
    repeat (2) @(negedge clk);
    pc_load = 1'b1; pc_new = 32'h40;
    @(negedge clk); pc_load = 1'b0;
    chk("R10 addr", mem_addr, 32'h40);
    chk("R10 valid dropped", 32'(out_valid), 0);
    wait_valid(n);
    chk("R10 refetch cycles", 32'(n), 2);
    chk("R10 icode", 32'(icode), 2);
    chk("R10 ra", 32'(ra), 4);
    chk("R10 rb", 32'(rb), 3);

    // Random program: R2..R7, ends with halt for R9
    clear_mem();
    gen_prog();
    do_reset();
    for (int i = 0; i < NI; i++) begin
      wait_valid(n);
      chk("R2 valid arrives", 32'(out_valid), 1);
      for (int d = $urandom % 3; d > 0; d--) begin
        @(negedge clk);
        chk("R7 held", 32'(out_valid), 1);
      end
      chk("R3 icode", 32'(icode), 32'(e_ic[i]));
      chk("R3 ifun", 32'(ifun), 32'(e_fn[i]));
      chk("R4 ra", 32'(ra), 32'(e_ra[i]));
      chk("R4 rb", 32'(rb), 32'(e_rb[i]));
      chk("R5 valc", valc, e_vc[i]);
      chk("R6 next_pc", next_pc, e_np[i]);
      chk("R8 no bad", 32'(bad_instr), 0);
      out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
      if (i < NI - 1) chk("R7 resume addr", mem_addr, e_np[i]);
    end
    chk("R9 halted", 32'(halted), 1);
    pc_load = 1'b1; pc_new = 32'h0;
    @(negedge clk); pc_load = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 pc_load ignored", 32'(halted), 1);
    chk("R9 no output", 32'(out_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule